// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block is the digital half of a fractional-N frequency synthesizer that builds a double-rate video sample clock from a crystal reference. It runs on the synthesized (oscillator) clock. It counts feedback periods whose length, the modulus, alternates between an integer setting N and N+1. A 16-bit phase accumulator decides which length each period gets, so the average feedback ratio is N plus the fraction over 65536. It also divides the reference pulses by a selectable pre-divide ratio for the phase detector. It divides the synthesized clock by a selectable post-divide ratio to make an output enable. The resulting frequency is the reference divided by the pre-divide ratio, multiplied by integer.fraction, then divided by the post-divide ratio. For example, integer 0x0E with fraction 0xDCF9, pre-divide 2 and post-divide 6 give about 35.469 MHz from 28.63636 MHz.

An integer setting of zero is the power-down command. It stops all counting, clears the accumulator and holds every output low. Settings taken while running are staged and applied only at an accumulator wrap, so no period ever mixes old and new values. The outputs are a real-time clock path that cannot stall, so every pin is plain and none is a valid/ready stream: a consumer gets no back-pressure and must take each strobe in the cycle it appears.

Top module: `fracn_divider_ctrl`

## Requirements
- R1: While reset is asserted, pwr_dn is 1, mod_val is 0 and fb_pulse, fb_plus, post_en and ref_en are 0.
- R2: When cfg_int is 0 at a clock edge, from that edge on pwr_dn is 1, mod_val is 0 and fb_pulse, fb_plus, post_en and ref_en stay 0 regardless of ref_pulse.
- R3: On leaving power-down, all four settings load together. In the first cycle with pwr_dn 0, mod_val equals cfg_int. The accumulator starts from zero, so the first period ends with fb_plus 0.
- R4: Each feedback period lasts exactly mod_val clocks. fb_pulse is high in its last clock only, and mod_val changes only on the clock after an fb_pulse.
- R5: At the end of every period the 16-bit accumulator adds the fraction. On carry-out the next period's modulus is integer+1, and fb_plus is 1 in that period's final clock; otherwise the modulus is the integer.
- R6: Among the n periods after the first one following a restart, the count with fb_plus set is floor(n*fraction/65536). Any 65536 consecutive periods contain exactly fraction such periods.
- R7: The number of clocks from the first fb_pulse after a restart to the n-th fb_pulse after it is n*integer plus the count from R6.
- R8: Settings changed while running take effect only at the end of a period that ended with fb_plus 1, or at the end of any period when the active fraction is zero.
- R9: cfg_post selects the post-divide ratio: 0 gives 6, 1 gives 4, 2 gives 3, 3 gives 2. post_en is one clock wide, once every ratio clocks.
- R10: cfg_pre selects the pre-divide ratio: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. ref_en goes high together with every ratio-th ref_pulse.
- R11: Integer 0x0E, fraction 0xDCF9, cfg_pre 1 and cfg_post 0 give an average feedback ratio of 14 + 56569/65536 under the counts of R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized clock |
| rst_n | input | 1 | Active-low reset |
| cfg_int | input | INT_W | Integer multiplier; 0 commands power-down |
| cfg_frac | input | FRAC_W | Fractional multiplier in 1/65536 steps |
| cfg_pre | input | 2 | Reference pre-divide select |
| cfg_post | input | 2 | Output post-divide select |
| ref_pulse | input | 1 | One-clock pulse per reference cycle |
| fb_pulse | output | 1 | Last clock of each feedback period |
| fb_plus | output | 1 | With fb_pulse: the period was integer+1 long |
| mod_val | output | INT_W+1 | Modulus of the current period |
| post_en | output | 1 | Post-divided output enable |
| ref_en | output | 1 | Pre-divided reference enable |
| pwr_dn | output | 1 | Power-down state |

## Verification
A table of settings covers several fraction patterns. A quarter fraction gives an exact periodic carry. A zero fraction must never produce an N+1 period. An all-ones fraction must carry on nearly every period. A fraction of one must give no carry in a short window, and the odd 0xDCF9 value tells rounding errors apart from exact floor counting. The same rows step through every pre-divide and post-divide code, so a wrong ratio decode shows up as a wrong interval. Directed runs change settings right after a non-carry period, and again with a zero fraction, to separate staged updates from immediate ones. They also drop into power-down mid-run with reference pulses still arriving.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int SEL_W   = 2;
  localparam int RATIO_W = 4;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    sel_t pre;
    sel_t post;
  } div_sel_t;

  typedef enum logic [SEL_W-1:0] {
    POST_DIV6 = 2'd0,
    POST_DIV4 = 2'd1,
    POST_DIV3 = 2'd2,
    POST_DIV2 = 2'd3
  } post_code_e;

  function automatic logic [RATIO_W-1:0] post_ratio(input sel_t code);
    case (post_code_e'(code))
      POST_DIV6: return RATIO_W'(6);
      POST_DIV4: return RATIO_W'(4);
      POST_DIV3: return RATIO_W'(3);
      default:   return RATIO_W'(2);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] pre_ratio(input sel_t code);
    return RATIO_W'(1) << code;
  endfunction

endpackage

// File: rtl/fracn_cfg_shadow.sv
module fracn_cfg_shadow
  import fracn_pkg::*;
#(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  div_sel_t          cfg_sel,
  input  logic              fb_pulse,
  input  logic              cur_carry,
  output logic              pwr_q,
  output logic              start,
  output logic [INT_W-1:0]  nxt_int,
  output logic [FRAC_W-1:0] nxt_frac,
  output div_sel_t          act_sel
);

  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              wrap_pt;
  logic              loading;

  // leaving power-down needs a non-zero integer
  assign start   = pwr_q && (cfg_int != '0);
  // a wrap point: period ended on a carry, or fraction idle
  assign wrap_pt = fb_pulse && (cur_carry || (act_frac == '0));
  assign loading = start || wrap_pt;

  assign nxt_int  = loading ? cfg_int  : act_int;
  assign nxt_frac = loading ? cfg_frac : act_frac;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q    <= 1'b1;
      act_int  <= '0;
      act_frac <= '0;
      act_sel  <= '0;
    end else if (cfg_int == '0) begin
      pwr_q <= 1'b1;
    end else begin
      pwr_q <= 1'b0;
      if (loading) begin
        act_int  <= cfg_int;
        act_frac <= cfg_frac;
        act_sel  <= cfg_sel;
      end
    end
  end

endmodule

// File: rtl/fracn_sigma_acc.sv
module fracn_sigma_acc #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 16,
  localparam int MOD_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_q,
  input  logic              start,
  input  logic              fb_pulse,
  input  logic [INT_W-1:0]  nxt_int,
  input  logic [FRAC_W-1:0] nxt_frac,
  output logic [MOD_W-1:0]  cur_mod,
  output logic              cur_carry
);

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, nxt_frac};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cur_carry <= 1'b0;
      cur_mod   <= '0;
    end else if (start) begin
      acc       <= '0;
      cur_carry <= 1'b0;
      cur_mod   <= {1'b0, nxt_int};
    end else if (pwr_q) begin
      acc       <= '0;
      cur_carry <= 1'b0;
      cur_mod   <= '0;
    end else if (fb_pulse) begin
      acc       <= sum[FRAC_W-1:0];
      cur_carry <= sum[FRAC_W];
      cur_mod   <= {1'b0, nxt_int} + MOD_W'(sum[FRAC_W]);
    end
  end

endmodule

// File: rtl/fracn_mod_counter.sv
module fracn_mod_counter #(
  parameter int MOD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_q,
  input  logic [MOD_W-1:0] cur_mod,
  output logic             fb_pulse
);

  logic [MOD_W-1:0] cnt;
  logic             last;

  assign last     = (cur_mod != '0) && (cnt >= cur_mod - MOD_W'(1));
  assign fb_pulse = !pwr_q && last;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_q) cnt <= '0;
    else if (last)       cnt <= '0;
    else                 cnt <= cnt + MOD_W'(1);
  end

endmodule

// File: rtl/fracn_ratio_div.sv
module fracn_ratio_div #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_q,
  input  logic               step,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);

  logic [RATIO_W-1:0] cnt;
  logic               at_end;

  assign at_end = (cnt >= ratio - RATIO_W'(1));
  assign tick   = !pwr_q && step && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_q) cnt <= '0;
    else if (step)       cnt <= at_end ? '0 : cnt + RATIO_W'(1);
  end

endmodule

// File: rtl/fracn_divider_ctrl.sv
module fracn_divider_ctrl
  import fracn_pkg::*;
#(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic [SEL_W-1:0]  cfg_pre,
  input  logic [SEL_W-1:0]  cfg_post,
  input  logic              ref_pulse,
  output logic              fb_pulse,
  output logic              fb_plus,
  output logic [INT_W:0]    mod_val,
  output logic              post_en,
  output logic              ref_en,
  output logic              pwr_dn
);

  localparam int MOD_W   = INT_W + 1;
  localparam int NUM_DIV = 2;   // index 0: reference side, 1: output side

  logic              pwr_q;
  logic              start;
  logic [INT_W-1:0]  nxt_int;
  logic [FRAC_W-1:0] nxt_frac;
  div_sel_t          act_sel;
  div_sel_t          cfg_sel;
  logic [MOD_W-1:0]  cur_mod;
  logic              cur_carry;
  logic              pulse_int;

  assign cfg_sel = '{pre: cfg_pre, post: cfg_post};

  fracn_cfg_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_int  (cfg_int),
    .cfg_frac (cfg_frac),
    .cfg_sel  (cfg_sel),
    .fb_pulse (pulse_int),
    .cur_carry(cur_carry),
    .pwr_q    (pwr_q),
    .start    (start),
    .nxt_int  (nxt_int),
    .nxt_frac (nxt_frac),
    .act_sel  (act_sel)
  );

  fracn_sigma_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sigma (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_q    (pwr_q),
    .start    (start),
    .fb_pulse (pulse_int),
    .nxt_int  (nxt_int),
    .nxt_frac (nxt_frac),
    .cur_mod  (cur_mod),
    .cur_carry(cur_carry)
  );

  fracn_mod_counter #(.MOD_W(MOD_W)) u_modcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_q   (pwr_q),
    .cur_mod (cur_mod),
    .fb_pulse(pulse_int)
  );

  logic [NUM_DIV-1:0] step_v;
  logic [NUM_DIV-1:0] tick_v;
  logic [RATIO_W-1:0] ratio_v [NUM_DIV];

  assign step_v     = {1'b1, ref_pulse};
  assign ratio_v[0] = pre_ratio(act_sel.pre);
  assign ratio_v[1] = post_ratio(act_sel.post);

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    fracn_ratio_div #(.RATIO_W(RATIO_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .pwr_q(pwr_q),
      .step (step_v[d]),
      .ratio(ratio_v[d]),
      .tick (tick_v[d])
    );
  end

  assign fb_pulse = pulse_int;
  assign fb_plus  = pulse_int && cur_carry;
  assign mod_val  = pwr_q ? '0 : cur_mod;
  assign ref_en   = tick_v[0];
  assign post_en  = tick_v[1];
  assign pwr_dn   = pwr_q;

endmodule

// File: rtl/fracn_divider_ctrl_chk.sv
module fracn_divider_ctrl_chk #(
  parameter int INT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [INT_W-1:0] cfg_int,
  input logic             fb_pulse,
  input logic             fb_plus,
  input logic [INT_W:0]   mod_val,
  input logic             post_en,
  input logic             ref_en,
  input logic             pwr_dn
);

  // R2
  pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_int == '0) |=> pwr_dn);

  // R2
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!fb_pulse && !fb_plus && !post_en && !ref_en && mod_val == '0));

  // R3
  restart_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && cfg_int != '0) |=> (!pwr_dn && mod_val == {1'b0, $past(cfg_int)}));

  // R4
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && !fb_pulse && cfg_int != '0) |=> $stable(mod_val));

  // R5
  plus_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_plus |-> fb_pulse);

  // R9
  post_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_en |=> !post_en);

endmodule

bind fracn_divider_ctrl fracn_divider_ctrl_chk #(.INT_W(INT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_int (cfg_int),
  .fb_pulse(fb_pulse),
  .fb_plus (fb_plus),
  .mod_val (mod_val),
  .post_en (post_en),
  .ref_en  (ref_en),
  .pwr_dn  (pwr_dn)
);

// File: tb/fracn_divider_ctrl_test.sv
module fracn_divider_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_int = 6'd10;
  logic [15:0] cfg_frac = 16'h4000;
  logic [1:0] cfg_pre = 2'd0;
  logic [1:0] cfg_post = 2'd0;
  logic       ref_pulse = 1'b0;
  logic       fb_pulse, fb_plus, post_en, ref_en, pwr_dn;
  logic [6:0] mod_val;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  fracn_divider_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_int(cfg_int), .cfg_frac(cfg_frac),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .fb_plus(fb_plus), .mod_val(mod_val),
    .post_en(post_en), .ref_en(ref_en), .pwr_dn(pwr_dn)
  );

  typedef struct packed {
    logic [7:0]  n_int;
    logic [15:0] frac;
    logic [1:0]  pre;
    logic [1:0]  post;
    logic [15:0] win;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd10, 16'h4000, 2'd0, 2'd0, 16'd64},
    '{8'd14, 16'hDCF9, 2'd1, 2'd0, 16'd4096},
    '{8'd5,  16'h0000, 2'd2, 2'd1, 16'd64},
    '{8'd3,  16'hFFFF, 2'd3, 2'd2, 16'd64},
    '{8'd7,  16'h0001, 2'd1, 2'd3, 16'd300},
    '{8'd1,  16'h8000, 2'd0, 2'd3, 16'd64}
  };

  // reference pulse every third clock
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == 2) ? 0 : ph + 1;
      ref_pulse = (ph == 0);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic restart(input int n, input int f, input int p, input int q);
    @(negedge clk);
    cfg_int = 6'd0;
    repeat (3) @(negedge clk);
    cfg_frac = 16'(f);
    cfg_pre  = 2'(p);
    cfg_post = 2'(q);
    cfg_int  = 6'(n);
    @(negedge clk);
    check(pwr_dn == 1'b0 && mod_val == 7'(n), "R3 restart modulus", mod_val, n);
  endtask

  function automatic int post_r(input int s);
    case (s)
      0: return 6;
      1: return 4;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(pwr_dn == 1'b1 && mod_val == 7'd0, "R1 reset pwr_dn/mod_val", {pwr_dn, mod_val}, 8'h80);
    check(!fb_pulse && !fb_plus && !post_en && !ref_en, "R1 reset strobes", {fb_pulse, fb_plus, post_en, ref_en}, 0);
    rst_n = 1'b1;

    // table of settings
    for (int i = 0; i < 6; i++) begin
      int n_int, frac, pre, post, win;
      int n, pulses, plus, pl1, pl2, rl1, rl2;
      longint exp_plus, exp_clk;
      string tag;
      n_int = int'(VECS[i].n_int);
      frac  = int'(VECS[i].frac);
      pre   = int'(VECS[i].pre);
      post  = int'(VECS[i].post);
      win   = int'(VECS[i].win);
      restart(n_int, frac, pre, post);
      wait_pulse();
      check(fb_plus == 1'b0, "R3 first period not extended", fb_plus, 0);
      n = 0; pulses = 0; plus = 0; pl1 = -1; pl2 = -1; rl1 = -1; rl2 = -1;
      while (pulses < win) begin
        @(negedge clk);
        n++;
        if (fb_pulse) begin
          pulses++;
          if (fb_plus) plus++;
        end
        if (post_en) begin
          if (pl1 < 0) pl1 = n; else if (pl2 < 0) pl2 = n;
        end
        if (ref_en) begin
          if (rl1 < 0) rl1 = n; else if (rl2 < 0) rl2 = n;
        end
      end
      exp_plus = (longint'(win) * longint'(frac)) >>> 16;
      exp_clk  = longint'(win) * longint'(n_int) + exp_plus;
      tag = (i == 1) ? "R11 example carries" : "R6 carry count";
      check(plus == exp_plus, tag, plus, exp_plus);
      tag = (i == 1) ? "R11 example clocks" : "R7 clock count";
      check(n == exp_clk, tag, n, exp_clk);
      check(pl2 - pl1 == post_r(post), "R9 post interval", pl2 - pl1, post_r(post));
      check(rl2 - rl1 == 3 * (1 << pre), "R10 ref interval", rl2 - rl1, 3 * (1 << pre));
    end

    // R8 staged update with a dithering fraction
    begin
      int n;
      restart(10, 16'h8000, 0, 0);
      wait_pulse();
      @(negedge clk);
      check(mod_val == 7'd10, "R5 no carry after first add", mod_val, 10);
      cfg_int = 6'd20;
      n = 1;
      while (!fb_pulse) begin @(negedge clk); n++; end
      check(n == 10, "R4 period length", n, 10);
      check(fb_plus == 1'b0, "R5 plus flag on plain period", fb_plus, 0);
      @(negedge clk);
      check(mod_val == 7'd11, "R8 old integer kept, R5 carry", mod_val, 11);
      wait_pulse();
      check(fb_plus == 1'b1, "R5 plus flag on extended period", fb_plus, 1);
      @(negedge clk);
      check(mod_val == 7'd20, "R8 new integer at wrap", mod_val, 20);
    end

    // R8 zero fraction applies at the next period end
    restart(9, 0, 0, 0);
    wait_pulse();
    @(negedge clk);
    check(mod_val == 7'd9, "R8 zero-fraction modulus", mod_val, 9);
    cfg_int = 6'd12;
    wait_pulse();
    @(negedge clk);
    check(mod_val == 7'd12, "R8 zero-fraction update", mod_val, 12);

    // R2 power-down mid-run
    begin
      int bad = 0;
      repeat (7) @(negedge clk);
      cfg_int = 6'd0;
      @(negedge clk);
      check(pwr_dn == 1'b1, "R2 enters power-down", pwr_dn, 1);
      repeat (40) begin
        @(negedge clk);
        if (fb_pulse || fb_plus || post_en || ref_en || mod_val != 7'd0) bad++;
      end
      check(bad == 0, "R2 outputs held low", bad, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule